// File: doc/BRIEF.md
# Packet-Aware Multi-Queue FIFO

This block holds several logical queues in one shared word store. Each word is 36 bits of data plus two marker bits, one for the first word of a packet and one for the last. A writer picks the target queue with a write-queue address. A reader picks the source queue with a separate read-queue address. Words enter through a valid/ready stream and leave through another. A write moves a word only when `s_valid` and `s_ready` are both high. `s_ready` drops while the selected write queue is full. A read pops a word only when `m_valid` and `m_ready` are both high. `m_valid` drops while the selected read queue is empty. `m_data` may change only after a pop or a change of read queue.

Three configuration pins are sampled while master reset is held. Together they choose how the read-side flags behave. In packet mode, the flags report whether a queue holds at least one complete packet. In almost-empty mode, they report whether the queue's word count has fallen to a threshold. A one-cycle active-low partial-reset pulse empties the queue that is selected on both ports. It leaves the mode and every other queue untouched.

Top module: `mq_pkt_fifo`

## Requirements
- R1: After master reset every queue is empty. `m_valid`=0, `s_ready`=1 and `pr_n`=1. Every bit of `flag_bus_n` and `flag_ae_n` is 0 in almost-empty mode and 1 in packet mode.
- R2: Each queue returns its words in write order. Each word keeps its data and its `sop`/`eop` markers, and queues do not disturb one another.
- R3: While the write queue holds DEPTH words, `s_ready`=0 and offered words are dropped. While the read queue is empty, `m_valid`=0 and pops do nothing.
- R4: The block enters packet mode only if `cfg_pkt`, `cfg_in36` and `cfg_out36` are all 1 on the last clock edge with `rst_n` low. Otherwise it enters almost-empty mode. Pin changes after reset have no effect.
- R5: In packet mode, `pr_n` and `flag_ae_n` are 0 exactly when the selected read queue holds a complete packet. A complete packet is one whose `eop` word has been written and not yet read. `flag_bus_n[q]` shows the same for queue q.
- R6: In almost-empty mode, `flag_ae_n` is 0 exactly when the selected read queue holds AE_LEVEL words or fewer. `flag_bus_n[q]` shows the same for queue q, and `pr_n` stays 1.
- R7: In packet mode, once a word with `sop`=1 and `eop`=0 has been accepted, a different `wr_qsel` is ignored until the packet's `eop` word is accepted. For each clock edge where such a change is refused, `sw_err` is 1 in the following cycle.
- R8: When `prs_n`=0 for one edge while the write and read queues are the same, that queue is emptied and its packet count is cleared. The mode and the other queues are unchanged. When the write and read queues differ, the pulse is ignored.
- R9: A new `wr_qsel` or `rd_qsel` value takes effect one clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low |
| cfg_pkt | input | 1 | Packet-mode request, sampled during reset |
| cfg_in36 | input | 1 | Write port is full width, sampled during reset |
| cfg_out36 | input | 1 | Read port is full width, sampled during reset |
| prs_n | input | 1 | Partial reset of the commonly selected queue, active low |
| wr_qsel | input | 2 | Write-queue address |
| s_valid | input | 1 | Write word offered |
| s_ready | output | 1 | Write queue has space |
| s_data | input | 36 | Write data |
| s_sop | input | 1 | First word of packet |
| s_eop | input | 1 | Last word of packet |
| rd_qsel | input | 2 | Read-queue address |
| m_valid | output | 1 | Read queue not empty |
| m_ready | input | 1 | Reader takes word |
| m_data | output | 36 | Read data |
| m_sop | output | 1 | Head word starts a packet |
| m_eop | output | 1 | Head word ends a packet |
| flag_ae_n | output | 1 | Read-queue flag: almost-empty or packet-ready, active low |
| pr_n | output | 1 | Packet ready, active low, packet mode only |
| flag_bus_n | output | 4 | Per-queue flag in the current mode, active low |
| sw_err | output | 1 | Refused mid-packet queue switch |

## Verification
Every queue is filled word by word up to full and past it, then drained. At each fill level the bench checks the almost-empty threshold on both the discrete flag and the bus, and the drain checks ordering and marker bits. Words interleaved across all queues and read back in reverse queue order show that the queues are separate. All eight combinations of the mode pins are swept, and the pins are flipped after reset, to show that only the all-ones case gives packet mode. In packet mode, multi-word and single-word packets show that the flag follows packet ends and not word counts. A switch attempted in mid-packet and partial resets aimed at matching and at mismatched queues show that stray switches and pulses are rejected.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int DW = 36;

  typedef struct packed {
    logic          sop;
    logic          eop;
    logic [DW-1:0] data;
  } mq_word_t;
endpackage

// File: rtl/mq_queue_state.sv
module mq_queue_state #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          push_eop,
  input  logic          pop,
  input  logic          pop_eop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] pkts,
  output logic          full,
  output logic          empty
);
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      pkts  <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      pkts  <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      count <= count + CW'(push) - CW'(pop);
      pkts  <= pkts + CW'(push && push_eop) - CW'(pop && pop_eop);
    end
  end

  // R3: no push into a full queue, no pop from an empty one
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R8: a partial reset leaves the queue empty with no packets
  p_clr_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && pkts == '0));
  // R5: complete packets never outnumber stored words
  p_pkts_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pkts <= count);
endmodule

// File: rtl/mq_wsel.sv
module mq_wsel #(
  parameter int NQ = 4,
  parameter int QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_mode,
  input  logic [QW-1:0] wr_qsel,
  input  logic          wr_fire,
  input  logic          wr_sop,
  input  logic          wr_eop,
  input  logic          clr_wq,
  output logic [QW-1:0] wr_cur,
  output logic          sw_err
);
  logic in_pkt;
  logic blocked;

  assign blocked = pkt_mode && in_pkt && (wr_qsel != wr_cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cur <= '0;
      sw_err <= 1'b0;
      in_pkt <= 1'b0;
    end else begin
      sw_err <= blocked;
      if (!blocked) wr_cur <= wr_qsel;
      if (clr_wq)                 in_pkt <= 1'b0;
      else if (wr_fire && wr_eop) in_pkt <= 1'b0;
      else if (wr_fire && wr_sop) in_pkt <= 1'b1;
    end
  end

  // R7: the write queue stays put while a packet is open in packet mode
  p_no_switch_midpkt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_mode && in_pkt) |=> (wr_cur == $past(wr_cur)));
  // R7: an error pulse always pairs with an unchanged queue
  p_err_keeps_queue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_err |-> $stable(wr_cur));
endmodule

// File: rtl/mq_store.sv
module mq_store #(
  parameter int NQ    = 4,
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(NQ * DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [LW-1:0]    waddr,
  input  mq_pkg::mq_word_t wdata,
  input  logic [LW-1:0]    raddr,
  output mq_pkg::mq_word_t rdata
);
  localparam int N = NQ * DEPTH;

  mq_pkg::mq_word_t mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mq_pkt_fifo.sv
module mq_pkt_fifo #(
  parameter int NQ       = 4,
  parameter int DEPTH    = 8,
  parameter int AE_LEVEL = 2,
  parameter int QW       = $clog2(NQ)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_pkt,
  input  logic                  cfg_in36,
  input  logic                  cfg_out36,
  input  logic                  prs_n,
  input  logic [QW-1:0]         wr_qsel,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [mq_pkg::DW-1:0] s_data,
  input  logic                  s_sop,
  input  logic                  s_eop,
  input  logic [QW-1:0]         rd_qsel,
  output logic                  m_valid,
  input  logic                  m_ready,
  output logic [mq_pkg::DW-1:0] m_data,
  output logic                  m_sop,
  output logic                  m_eop,
  output logic                  flag_ae_n,
  output logic                  pr_n,
  output logic [NQ-1:0]         flag_bus_n,
  output logic                  sw_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = $clog2(NQ * DEPTH);

  logic          pkt_mode;
  logic [QW-1:0] rd_cur;
  logic [QW-1:0] wr_cur;
  logic          clr_any;
  logic          wr_fire;
  logic          rd_fire;

  logic [AW-1:0] wptr  [NQ];
  logic [AW-1:0] rptr  [NQ];
  logic [CW-1:0] count [NQ];
  logic [CW-1:0] pkts  [NQ];
  logic [NQ-1:0] full;
  logic [NQ-1:0] empty;

  mq_pkg::mq_word_t wword;
  mq_pkg::mq_word_t rword;

  // Mode is captured on every edge while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) pkt_mode <= cfg_pkt & cfg_in36 & cfg_out36;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_cur <= '0;
    else        rd_cur <= rd_qsel;
  end

  assign clr_any = !prs_n && (wr_cur == rd_cur);
  assign s_ready = !full[wr_cur];
  assign m_valid = !empty[rd_cur];
  assign wr_fire = s_valid && s_ready && !clr_any;
  assign rd_fire = m_valid && m_ready && !clr_any;

  mq_wsel #(.NQ(NQ), .QW(QW)) u_wsel (
    .clk(clk), .rst_n(rst_n), .pkt_mode(pkt_mode), .wr_qsel(wr_qsel),
    .wr_fire(wr_fire), .wr_sop(s_sop), .wr_eop(s_eop), .clr_wq(clr_any),
    .wr_cur(wr_cur), .sw_err(sw_err)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    mq_queue_state #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_st (
      .clk(clk), .rst_n(rst_n),
      .clr(clr_any && (wr_cur == QW'(q))),
      .push(wr_fire && (wr_cur == QW'(q))), .push_eop(s_eop),
      .pop(rd_fire && (rd_cur == QW'(q))), .pop_eop(rword.eop),
      .wptr(wptr[q]), .rptr(rptr[q]), .count(count[q]), .pkts(pkts[q]),
      .full(full[q]), .empty(empty[q])
    );
    assign flag_bus_n[q] = pkt_mode ? (pkts[q] == '0)
                                    : (count[q] > CW'(AE_LEVEL));
  end

  assign wword = '{sop: s_sop, eop: s_eop, data: s_data};

  mq_store #(.NQ(NQ), .DEPTH(DEPTH), .LW(LW)) u_store (
    .clk(clk), .we(wr_fire),
    .waddr(LW'(wr_cur) * LW'(DEPTH) + LW'(wptr[wr_cur])),
    .wdata(wword),
    .raddr(LW'(rd_cur) * LW'(DEPTH) + LW'(rptr[rd_cur])),
    .rdata(rword)
  );

  assign m_data    = rword.data;
  assign m_sop     = rword.sop;
  assign m_eop     = rword.eop;
  assign flag_ae_n = flag_bus_n[rd_cur];
  assign pr_n      = pkt_mode ? flag_bus_n[rd_cur] : 1'b1;

  // R4: the mode never moves once reset is released
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(pkt_mode));
  // R6: the packet-ready output stays idle outside packet mode
  p_pr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_mode |-> pr_n);
  // R5: a ready packet implies a word to read
  p_ready_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_n |-> m_valid);
endmodule

// File: tb/tb_mq_pkt_fifo.sv
module tb_mq_pkt_fifo;
  localparam int NQ = 4, DEPTH = 4, AE = 1;

  logic clk = 0, rst_n = 0;
  logic cfg_pkt = 0, cfg_in36 = 0, cfg_out36 = 0, prs_n = 1;
  logic [1:0] wr_qsel = 0, rd_qsel = 0;
  logic s_valid = 0, s_sop = 0, s_eop = 0, m_ready = 0;
  logic [35:0] s_data = 0;
  logic s_ready, m_valid, m_sop, m_eop, flag_ae_n, pr_n, sw_err;
  logic [35:0] m_data;
  logic [NQ-1:0] flag_bus_n;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  mq_pkt_fifo #(.NQ(NQ), .DEPTH(DEPTH), .AE_LEVEL(AE)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic settle(); @(negedge clk); endtask
  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wsel(input logic [1:0] q); @(negedge clk); wr_qsel = q; tick(); endtask
  task automatic rsel(input logic [1:0] q); @(negedge clk); rd_qsel = q; tick(); endtask

  task automatic push(input logic [35:0] d, input logic sp, input logic ep);
    @(negedge clk); s_data = d; s_sop = sp; s_eop = ep; s_valid = 1;
    tick(); s_valid = 0; s_sop = 0; s_eop = 0;
  endtask

  task automatic pop(output logic v, output logic [35:0] d, output logic sp, output logic ep);
    @(negedge clk); v = m_valid; d = m_data; sp = m_sop; ep = m_eop; m_ready = 1;
    tick(); m_ready = 0;
  endtask

  task automatic do_reset(input logic p, input logic a, input logic b);
    @(negedge clk); rst_n = 0; cfg_pkt = p; cfg_in36 = a; cfg_out36 = b;
    wr_qsel = 0; rd_qsel = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic prs_pulse(); @(negedge clk); prs_n = 0; tick(); prs_n = 1; endtask

  initial begin
    #(5.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic v, sp, ep;
    logic [35:0] d;

    // Almost-empty mode
    do_reset(0, 1, 1);
    settle();
    chk(m_valid == 0, "R1 m_valid", m_valid, 0);
    chk(s_ready == 1, "R1 s_ready", s_ready, 1);
    chk(pr_n == 1, "R1 pr_n", pr_n, 1);
    chk(flag_ae_n == 0, "R1 flag_ae_n", flag_ae_n, 0);
    chk(flag_bus_n == 4'h0, "R1 flag_bus_n", flag_bus_n, 0);

    // Fill and drain every queue, threshold sweep
    for (int q = 0; q < NQ; q++) begin
      wsel(q[1:0]); rsel(q[1:0]);
      for (int k = 1; k <= DEPTH; k++) begin
        push(36'(q * 16 + k), k == 1, k == DEPTH);
        settle();
        chk(flag_ae_n == (k > AE), "R6 flag_ae_n level", flag_ae_n, 64'(k > AE));
        chk(flag_bus_n == ((k > AE) ? 4'(1 << q) : 4'h0), "R6 flag_bus_n level",
            flag_bus_n, (k > AE) ? 64'(1 << q) : 0);
      end
      settle();
      chk(s_ready == 0, "R3 s_ready full", s_ready, 0);
      push(36'hEEE, 0, 0);
      for (int k = 1; k <= DEPTH; k++) begin
        pop(v, d, sp, ep);
        chk(v == 1 && d == 36'(q * 16 + k), "R2 order", d, 64'(q * 16 + k));
        chk(sp == (k == 1) && ep == (k == DEPTH), "R2 markers", {sp, ep}, {k == 1, k == DEPTH});
      end
      settle();
      chk(m_valid == 0, "R3 empty after drain (extra word dropped)", m_valid, 0);
      chk(pr_n == 1, "R6 pr_n idle", pr_n, 1);
      pop(v, d, sp, ep);
      chk(v == 0, "R3 pop on empty", v, 0);
    end

    // Interleave across queues, read in reverse queue order
    for (int q = 0; q < NQ; q++) begin wsel(q[1:0]); push(36'(100 + q), 1, 1); end
    for (int q = NQ - 1; q >= 0; q--) begin
      rsel(q[1:0]);
      pop(v, d, sp, ep);
      chk(v == 1 && d == 36'(100 + q), "R9 R2 queue separation", d, 64'(100 + q));
    end

    // Partial reset, mismatched then matched selection
    wsel(1);
    for (int k = 0; k < 3; k++) push(36'(200 + k), 0, 0);
    wsel(2);
    push(300, 0, 0); push(301, 0, 0);
    rsel(0); tick();
    prs_pulse();
    rsel(2); settle();
    chk(m_valid == 1 && m_data == 300, "R8 mismatched pulse ignored", m_data, 300);
    wsel(1); rsel(1); tick();
    prs_pulse(); settle();
    chk(m_valid == 0, "R8 queue emptied", m_valid, 0);
    chk(flag_ae_n == 0, "R8 flag after clear", flag_ae_n, 0);
    rsel(2); settle();
    chk(m_data == 300, "R8 other queue kept", m_data, 300);
    pop(v, d, sp, ep); pop(v, d, sp, ep);
    chk(d == 301, "R8 other queue tail", d, 301);

    // Mode pin sweep
    for (int c = 0; c < 8; c++) begin
      logic ep_mode;
      ep_mode = (c == 7);
      do_reset(c[2], c[1], c[0]);
      cfg_pkt = ~c[2]; cfg_in36 = ~c[1]; cfg_out36 = ~c[0];
      settle();
      chk(flag_ae_n == ep_mode, "R4 R1 empty flag by mode", flag_ae_n, 64'(ep_mode));
      chk(flag_bus_n == {4{ep_mode}}, "R1 flag_bus_n by mode", flag_bus_n, {4{ep_mode}});
      push(1, 1, 1); settle();
      chk(pr_n == !ep_mode, "R4 pr_n by mode", pr_n, 64'(!ep_mode));
    end
    // now in packet mode with one packet in q0
    pop(v, d, sp, ep); settle();
    chk(pr_n == 1, "R5 pr_n after last eop read", pr_n, 1);

    // Packet-ready tracking
    wsel(2); rsel(2);
    push(10, 1, 0); settle();
    chk(pr_n == 1, "R5 open packet not ready", pr_n, 1);
    push(11, 0, 0); settle();
    chk(pr_n == 1, "R5 middle word not ready", pr_n, 1);
    push(12, 0, 1); settle();
    chk(pr_n == 0 && flag_ae_n == 0, "R5 ready after eop", pr_n, 0);
    chk(flag_bus_n == 4'b1011, "R5 bus bit", flag_bus_n, 4'b1011);
    push(13, 1, 1);
    for (int k = 0; k < 3; k++) pop(v, d, sp, ep);
    settle();
    chk(d == 12 && pr_n == 0, "R5 one packet left", pr_n, 0);
    pop(v, d, sp, ep); settle();
    chk(d == 13 && pr_n == 1 && m_valid == 0, "R5 none left", pr_n, 1);

    // Mid-packet switch refused
    wsel(0);
    push(20, 1, 0);
    @(negedge clk); wr_qsel = 3; tick(); settle();
    chk(sw_err == 1, "R7 error pulse", sw_err, 1);
    push(21, 0, 1);
    tick(); settle();
    chk(sw_err == 0, "R7 error cleared after eop", sw_err, 0);
    push(22, 1, 1);
    rsel(0);
    pop(v, d, sp, ep);
    chk(d == 20, "R7 first word kept in old queue", d, 20);
    pop(v, d, sp, ep);
    chk(d == 21, "R7 refused switch kept queue", d, 21);
    rsel(3); settle();
    chk(m_data == 22 && pr_n == 0, "R7 switch after eop", m_data, 22);
    pop(v, d, sp, ep);

    // Partial reset clears packet count, mode kept
    wsel(1); rsel(1);
    push(5, 1, 1); settle();
    chk(pr_n == 0, "R8 packet before clear", pr_n, 0);
    tick();
    prs_pulse(); settle();
    chk(pr_n == 1 && m_valid == 0, "R8 packet count cleared", pr_n, 1);
    push(6, 1, 1); settle();
    chk(pr_n == 0, "R8 mode kept", pr_n, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule